// File: doc/BRIEF.md
# NAND Page Access Command Sequencer

This block converts one high-level flash request into the ordered series of primitives that a lower-level NAND engine executes: command bytes, address bytes and transfers between the flash and one area of a staging buffer. A request carries an opcode, a column, a page (row) address, a flag for large-page devices (2048-byte main area, otherwise 512 bytes) and a flag for high-density devices. The sequencer works out how many column and row cycles are needed and which confirm and pointer commands are required. It then hands the primitives out one at a time, waiting for the engine to acknowledge each one before it presents the next.

A request is taken only while the block is idle. `busy` stays high from the cycle after acceptance until the last primitive is acknowledged, and `done` then pulses for one cycle. Error correction and moving host data in and out of the buffer are handled elsewhere.

Top module: `nand_seq`

## Requirements
- R1: With `busy` low, a request whose `req_op` is one of 0 read page, 1 read spare, 2 program, 3 erase, 4 read ID, 5 read status or 6 reset is accepted at the clock edge. On the next cycle `busy` and `prim_valid` are high and the first primitive is presented.
- R2: A request with `req_op` = 7 is ignored: `busy` and `prim_valid` stay low.
- R3: A request raised while `busy` is high is ignored. The running sequence carries on unchanged and no further sequence follows it.
- R4: `prim_kind` is encoded as 0 command (data = command byte), 1 address (data = address byte), 2 buffer-to-flash transfer, 3 flash-to-buffer transfer, 4 ID transfer and 5 status transfer (for 2 to 5, data = buffer area index). A presented primitive stays stable until `prim_ack`. One cycle after the final acknowledge, `done` is high for exactly one cycle and `busy` is low.
- R5: Column cycles always carry 0x00. Reads and programs send one column cycle on small-page devices and two on large-page devices. Read ID sends a single 0x00 address cycle. Erase sends no column cycle.
- R6: Row cycles carry page bits 7:0, then 15:8, then (only when `req_dense` is high) 23:16. There are three row cycles when the density flag is high and two otherwise.
- R7: `prim_last` is high on the final address cycle of a sequence and low on every other primitive.
- R8: A read sends command 0x00, except that a spare read on a small-page device sends 0x50. The address cycles follow. A large-page device then gets command 0x30 and flash-to-buffer transfers on areas 0, 1, 2 and 3 in that order. A small-page device gets one transfer on area 0.
- R9: A program on a small-page device first sends 0x50 if the column is at least 512, and 0x00 otherwise. Every program then sends 0x80, the address cycles, buffer-to-flash transfers (areas 0 to 3 on large-page devices, area 0 on small-page devices) and finally 0x10.
- R10: An erase sends 0x60, the row cycles only, and then 0xD0.
- R11: Read ID sends 0x90, one address cycle and an ID transfer on area 0. Read status sends 0x70 and a status transfer on area 1. Reset sends the single command 0xFF.
- R12: Synchronous reset, including reset in the middle of a sequence, returns the block to idle with `busy`, `done` and `prim_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Request opcode |
| req_col | input | COL_W | Column of the request |
| req_page | input | PAGE_W | Page (row) address |
| req_big | input | 1 | Large-page device when high |
| req_dense | input | 1 | Density needs a third row cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| prim_valid | output | 1 | A primitive is presented |
| prim_kind | output | 3 | Primitive kind |
| prim_data | output | 8 | Command byte, address byte or area index |
| prim_last | output | 1 | Final address cycle marker |
| prim_ack | input | 1 | Engine has completed the primitive |

## Verification
The bench builds the block with its defaults: a 12-bit column, a 24-bit page address and a 512-byte small-page main area. With these values a single build covers both page sizes and both densities, because those are chosen per request. The 512 threshold lets small-page program columns fall on either side of the spare boundary, and the 24-bit page gives every row byte a distinct value, so a wrong byte order shows up. Acknowledge latencies from zero to three idle cycles test the hold-until-acknowledge behaviour.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  typedef enum logic [2:0] {
    K_CMD = 3'd0, K_ADDR = 3'd1, K_DIN = 3'd2, K_DOUT = 3'd3, K_ID = 3'd4, K_STAT = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    PH_PRE = 3'd0, PH_CMD = 3'd1, PH_COL = 3'd2, PH_ROW = 3'd3,
    PH_RCONF = 3'd4, PH_XFER = 3'd5, PH_POST = 3'd6, PH_IDLE = 3'd7
  } phase_e;

  localparam logic [2:0] OP_READ   = 3'd0;
  localparam logic [2:0] OP_RSPARE = 3'd1;
  localparam logic [2:0] OP_PROG   = 3'd2;
  localparam logic [2:0] OP_ERASE  = 3'd3;
  localparam logic [2:0] OP_ID     = 3'd4;
  localparam logic [2:0] OP_STAT   = 3'd5;
  localparam logic [2:0] OP_RESET  = 3'd6;

  localparam logic [7:0] B_PTR_MAIN  = 8'h00;
  localparam logic [7:0] B_PTR_SPARE = 8'h50;
  localparam logic [7:0] B_RD_CONF   = 8'h30;
  localparam logic [7:0] B_WR_SETUP  = 8'h80;
  localparam logic [7:0] B_WR_CONF   = 8'h10;
  localparam logic [7:0] B_ER_SETUP  = 8'h60;
  localparam logic [7:0] B_ER_CONF   = 8'hD0;
  localparam logic [7:0] B_ID        = 8'h90;
  localparam logic [7:0] B_STAT      = 8'h70;
  localparam logic [7:0] B_RESET     = 8'hFF;

  // Shape of one sequence: a count for each phase, plus the bytes it uses.
  typedef struct packed {
    logic       pre_en;
    logic [7:0] pre_b;
    logic [7:0] cmd_b;
    logic [1:0] ncol;
    logic [1:0] nrow;
    logic       rconf;
    logic [2:0] nxfer;
    kind_e      xkind;
    logic [1:0] xbase;
    logic       post_en;
    logic [7:0] post_b;
  } plan_t;
endpackage

// File: rtl/nseq_plan.sv
module nseq_plan
  import nseq_pkg::*;
#(
  parameter int COL_W      = 12,
  parameter int SMALL_MAIN = 512
) (
  input  logic [2:0]       op,
  input  logic [COL_W-1:0] col,
  input  logic             big,
  input  logic             dense,
  output plan_t            plan,
  output logic             op_ok
);
  localparam logic [COL_W-1:0] SPARE_START = COL_W'(SMALL_MAIN);

  logic [1:0] ncol_rw, nrow;
  logic [2:0] nxfer_rw;

  assign ncol_rw  = big ? 2'd2 : 2'd1;
  assign nrow     = dense ? 2'd3 : 2'd2;
  assign nxfer_rw = big ? 3'd4 : 3'd1;
  assign op_ok    = (op != 3'd7);

  always_comb begin
    plan = '0;
    plan.xkind = K_DOUT;
    unique case (op)
      OP_READ, OP_RSPARE: begin
        plan.cmd_b = (op == OP_RSPARE && !big) ? B_PTR_SPARE : B_PTR_MAIN;
        plan.ncol  = ncol_rw;
        plan.nrow  = nrow;
        plan.rconf = big;
        plan.nxfer = nxfer_rw;
        plan.xkind = K_DOUT;
      end
      OP_PROG: begin
        plan.pre_en  = !big;
        plan.pre_b   = (col >= SPARE_START) ? B_PTR_SPARE : B_PTR_MAIN;
        plan.cmd_b   = B_WR_SETUP;
        plan.ncol    = ncol_rw;
        plan.nrow    = nrow;
        plan.nxfer   = nxfer_rw;
        plan.xkind   = K_DIN;
        plan.post_en = 1'b1;
        plan.post_b  = B_WR_CONF;
      end
      OP_ERASE: begin
        plan.cmd_b   = B_ER_SETUP;
        plan.nrow    = nrow;
        plan.post_en = 1'b1;
        plan.post_b  = B_ER_CONF;
      end
      OP_ID: begin
        plan.cmd_b = B_ID;
        plan.ncol  = 2'd1;
        plan.nxfer = 3'd1;
        plan.xkind = K_ID;
      end
      OP_STAT: begin
        plan.cmd_b = B_STAT;
        plan.nxfer = 3'd1;
        plan.xkind = K_STAT;
        plan.xbase = 2'd1;
      end
      default: plan.cmd_b = B_RESET;
    endcase
  end
endmodule

// File: rtl/nseq_emit.sv
module nseq_emit
  import nseq_pkg::*;
#(
  parameter int PAGE_W = 24
) (
  input  phase_e            ph,
  input  logic [2:0]        idx,
  input  plan_t             plan,
  input  logic [PAGE_W-1:0] page,
  output kind_e             kind,
  output logic [7:0]        data,
  output logic              last
);
  logic [PAGE_W-1:0] page_sh;
  assign page_sh = page >> {idx, 3'b000};

  always_comb begin
    kind = K_CMD;
    data = 8'h00;
    last = 1'b0;
    unique case (ph)
      PH_PRE:   data = plan.pre_b;
      PH_CMD:   data = plan.cmd_b;
      PH_COL: begin
        kind = K_ADDR;
        last = (plan.nrow == 2'd0) && (idx == 3'(plan.ncol) - 3'd1);
      end
      PH_ROW: begin
        kind = K_ADDR;
        data = page_sh[7:0];
        last = (idx == 3'(plan.nrow) - 3'd1);
      end
      PH_RCONF: data = B_RD_CONF;
      PH_XFER: begin
        kind = plan.xkind;
        data = 8'(plan.xbase) + 8'(idx);
      end
      PH_POST:  data = plan.post_b;
      default:  ;
    endcase
  end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nseq_pkg::*;
#(
  parameter int COL_W      = 12,
  parameter int PAGE_W     = 24,
  parameter int SMALL_MAIN = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [COL_W-1:0]  req_col,
  input  logic [PAGE_W-1:0] req_page,
  input  logic              req_big,
  input  logic              req_dense,
  output logic              busy,
  output logic              done,
  output logic              prim_valid,
  output logic [2:0]        prim_kind,
  output logic [7:0]        prim_data,
  output logic              prim_last,
  input  logic              prim_ack
);
  plan_t             plan_d, plan_q, plan_use;
  logic              op_ok, accept, step;
  phase_e            phase_q, phase_n;
  logic [2:0]        idx_q, idx_n;
  logic [PAGE_W-1:0] page_q, page_use;
  kind_e             kind_n;
  logic [7:0]        data_n;
  logic              last_n;

  nseq_plan #(.COL_W(COL_W), .SMALL_MAIN(SMALL_MAIN)) u_plan (
    .op(req_op), .col(req_col), .big(req_big), .dense(req_dense),
    .plan(plan_d), .op_ok(op_ok)
  );

  function automatic logic [2:0] ph_cnt(input int p, input plan_t pl);
    case (p)
      0: ph_cnt = {2'b00, pl.pre_en};
      1: ph_cnt = 3'd1;
      2: ph_cnt = {1'b0, pl.ncol};
      3: ph_cnt = {1'b0, pl.nrow};
      4: ph_cnt = {2'b00, pl.rconf};
      5: ph_cnt = pl.nxfer;
      6: ph_cnt = {2'b00, pl.post_en};
      default: ph_cnt = 3'd0;
    endcase
  endfunction

  // First non-empty phase at or after 'from'; idle when none is left.
  function automatic phase_e first_ph(input int from, input plan_t pl);
    phase_e r = PH_IDLE;
    for (int p = 6; p >= 0; p--)
      if (p >= from && ph_cnt(p, pl) != 3'd0) r = phase_e'(p);
    return r;
  endfunction

  assign accept   = req_valid && !busy && op_ok;
  assign step     = busy && prim_ack;
  assign plan_use = accept ? plan_d : plan_q;
  assign page_use = accept ? req_page : page_q;

  always_comb begin
    phase_n = phase_q;
    idx_n   = idx_q;
    if (accept) begin
      phase_n = first_ph(0, plan_d);
      idx_n   = 3'd0;
    end else if (step) begin
      if (idx_q + 3'd1 < ph_cnt(int'(phase_q), plan_q)) begin
        idx_n = idx_q + 3'd1;
      end else begin
        phase_n = first_ph(int'(phase_q) + 1, plan_q);
        idx_n   = 3'd0;
      end
    end
  end

  nseq_emit #(.PAGE_W(PAGE_W)) u_emit (
    .ph(phase_n), .idx(idx_n), .plan(plan_use), .page(page_use),
    .kind(kind_n), .data(data_n), .last(last_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      idx_q      <= 3'd0;
      plan_q     <= '0;
      page_q     <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      prim_valid <= 1'b0;
      prim_kind  <= 3'd0;
      prim_data  <= 8'h00;
      prim_last  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      idx_q   <= idx_n;
      if (accept) begin
        plan_q <= plan_d;
        page_q <= req_page;
      end
      busy       <= (phase_n != PH_IDLE);
      prim_valid <= (phase_n != PH_IDLE);
      done       <= step && (phase_n == PH_IDLE);
      prim_kind  <= kind_n;
      prim_data  <= data_n;
      prim_last  <= last_n && (phase_n != PH_IDLE);
    end
  end

  // R4: a presented primitive is held until acknowledged
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    prim_valid && !prim_ack |=> prim_valid && $stable(prim_kind) && $stable(prim_data) && $stable(prim_last));

  // R4: the end pulse follows an acknowledge and leaves the block idle
  assert_done_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(prim_ack));

  // R2: an undefined opcode does not start a sequence
  assert_bad_op_R2: assert property (@(posedge clk) disable iff (rst)
    !busy && req_valid && req_op == 3'd7 |=> !busy);

  // R3: without an acknowledge a running sequence neither ends nor restarts
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (rst)
    busy && !prim_ack |=> busy && $stable(prim_data));

  // R7: the last marker only ever rides on an address cycle
  assert_last_addr_R7: assert property (@(posedge clk) disable iff (rst)
    prim_valid && prim_last |-> prim_kind == 3'd1);
endmodule

// File: tb/sim_nand_seq.sv
module sim_nand_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [11:0] req_col = '0;
  logic [23:0] req_page = '0;
  logic        req_big = 1'b0;
  logic        req_dense = 1'b0;
  logic        prim_ack = 1'b0;
  logic        busy, done, prim_valid, prim_last;
  logic [2:0]  prim_kind;
  logic [7:0]  prim_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  logic [2:0] ek [16];
  logic [7:0] ed [16];
  logic       el [16];
  int         en;

  always #5 clk = ~clk;

  nand_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_col(req_col),
    .req_page(req_page), .req_big(req_big), .req_dense(req_dense), .busy(busy),
    .done(done), .prim_valid(prim_valid), .prim_kind(prim_kind), .prim_data(prim_data),
    .prim_last(prim_last), .prim_ack(prim_ack)
  );

  // {expected count, op, big, dense, column, page, ack latency}
  localparam logic [47:0] VEC [12] = '{
    {5'd5,  3'd0, 1'b0, 1'b0, 12'h000, 24'h12_34_56, 2'd0},
    {5'd11, 3'd0, 1'b1, 1'b1, 12'h000, 24'hA5_C3_7E, 2'd1},
    {5'd6,  3'd1, 1'b0, 1'b1, 12'h000, 24'h0F_E1_29, 2'd2},
    {5'd10, 3'd1, 1'b1, 1'b0, 12'h000, 24'h00_B4_D7, 2'd0},
    {5'd7,  3'd2, 1'b0, 1'b0, 12'h010, 24'h00_21_43, 2'd3},
    {5'd8,  3'd2, 1'b0, 1'b1, 12'h205, 24'h6C_5A_18, 2'd0},
    {5'd11, 3'd2, 1'b1, 1'b1, 12'h810, 24'h3B_97_E2, 2'd1},
    {5'd5,  3'd3, 1'b0, 1'b1, 12'h000, 24'h44_88_CC, 2'd0},
    {5'd4,  3'd3, 1'b1, 1'b0, 12'h000, 24'h00_7D_91, 2'd2},
    {5'd3,  3'd4, 1'b1, 1'b1, 12'h000, 24'h00_00_00, 2'd0},
    {5'd2,  3'd5, 1'b0, 1'b0, 12'h000, 24'h00_00_00, 2'd1},
    {5'd1,  3'd6, 1'b1, 1'b0, 12'h000, 24'h00_00_00, 2'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] k, input logic [7:0] d, input logic l);
    ek[en] = k; ed[en] = d; el[en] = l; en++;
  endtask

  // Expected primitive list, written from the requirements.
  task automatic build(input logic [2:0] op, input logic big, input logic dense,
                       input logic [11:0] col, input logic [23:0] page);
    int nc = big ? 2 : 1;
    int nr = dense ? 3 : 2;
    int nx = big ? 4 : 1;
    en = 0;
    case (op)
      3'd0, 3'd1: begin
        push(3'd0, (op == 3'd1 && !big) ? 8'h50 : 8'h00, 1'b0);
        for (int c = 0; c < nc; c++) push(3'd1, 8'h00, 1'b0);
        for (int r = 0; r < nr; r++) push(3'd1, page[8*r +: 8], r == nr - 1);
        if (big) push(3'd0, 8'h30, 1'b0);
        for (int a = 0; a < nx; a++) push(3'd3, 8'(a), 1'b0);
      end
      3'd2: begin
        if (!big) push(3'd0, (col >= 12'd512) ? 8'h50 : 8'h00, 1'b0);
        push(3'd0, 8'h80, 1'b0);
        for (int c = 0; c < nc; c++) push(3'd1, 8'h00, 1'b0);
        for (int r = 0; r < nr; r++) push(3'd1, page[8*r +: 8], r == nr - 1);
        for (int a = 0; a < nx; a++) push(3'd2, 8'(a), 1'b0);
        push(3'd0, 8'h10, 1'b0);
      end
      3'd3: begin
        push(3'd0, 8'h60, 1'b0);
        for (int r = 0; r < nr; r++) push(3'd1, page[8*r +: 8], r == nr - 1);
        push(3'd0, 8'hD0, 1'b0);
      end
      3'd4: begin push(3'd0, 8'h90, 1'b0); push(3'd1, 8'h00, 1'b1); push(3'd4, 8'h00, 1'b0); end
      3'd5: begin push(3'd0, 8'h70, 1'b0); push(3'd5, 8'h01, 1'b0); end
      default: push(3'd0, 8'hFF, 1'b0);
    endcase
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R8";
      3'd2:       return "R9";
      3'd3:       return "R10";
      default:    return "R11";
    endcase
  endfunction

  task automatic run_seq(input logic [2:0] op, input logic big, input logic dense,
                         input logic [11:0] col, input logic [23:0] page,
                         input int lat, input bit intrude, input int exp_n);
    int got = 0;
    int guard = 0;
    string t = op_tag(op);
    build(op, big, dense, col, page);
    chk(en == exp_n, {t, " model length"}, en, exp_n);
    @(negedge clk);
    req_op = op; req_big = big; req_dense = dense; req_col = col; req_page = page;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && prim_valid, "R1 accept", {busy, prim_valid}, 2'b11);
    while (!done && guard < 500) begin
      guard++;
      if (prim_valid) begin
        if (got < 16) begin
          chk(prim_kind == ek[got] && prim_data == ed[got],
              (ek[got] == 3'd1) ? "R5 R6 address" : {t, " primitive"},
              {prim_kind, prim_data}, {ek[got], ed[got]});
          chk(prim_last == el[got], "R7 last marker", prim_last, el[got]);
        end
        if (intrude && got == 0) begin
          req_op = 3'd3; req_valid = 1'b1;
          @(negedge clk);
          req_valid = 1'b0;
        end
        for (int w = 0; w < lat; w++) @(negedge clk);
        chk(prim_valid, "R4 held until ack", prim_valid, 1);
        got++;
        prim_ack = 1'b1;
        @(negedge clk);
        prim_ack = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(got == exp_n, {t, " primitive count"}, got, exp_n);
    chk(done && !busy && !prim_valid, "R4 end pulse", {done, busy, prim_valid}, 3'b100);
    @(negedge clk);
    chk(!done && !busy, "R4 pulse width", {done, busy}, 2'b00);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !prim_valid, "R12 reset state", {busy, done, prim_valid}, 0);

    for (int i = 0; i < 12; i++) begin
      logic [47:0] v = VEC[i];
      run_seq(v[42:40], v[39], v[38], v[37:26], v[25:2], int'(v[1:0]), 1'b0, int'(v[47:43]));
    end

    // R2: undefined opcode
    @(negedge clk);
    req_op = 3'd7; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!busy && !prim_valid, "R2 opcode 7 ignored", {busy, prim_valid}, 0);
    @(negedge clk);
    chk(!busy && !done, "R2 stays idle", {busy, done}, 0);

    // R3: request while busy is dropped; the read finishes untouched
    run_seq(3'd0, 1'b0, 1'b1, 12'h000, 24'h9A_BC_DE, 1, 1'b1, 6);
    repeat (2) @(negedge clk);
    chk(!busy && !prim_valid, "R3 no queued sequence", {busy, prim_valid}, 0);

    // R12: reset in the middle of a sequence
    req_op = 3'd0; req_big = 1'b1; req_dense = 1'b1; req_page = 24'h11_22_33;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    prim_ack = 1'b1;
    repeat (2) @(negedge clk);
    prim_ack = 1'b0;
    chk(busy, "R12 busy before reset", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !prim_valid, "R12 mid-sequence reset", {busy, done, prim_valid}, 0);
    run_seq(3'd5, 1'b1, 1'b1, 12'h000, 24'h0, 0, 1'b0, 2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule